// File: doc/BRIEF.md
# Serial Majority-Vote Corrector for a (15,7) Cyclic Code

This block repairs a 15-bit received word of a (15,7) cyclic code with minimum distance 5. It corrects any pattern of one or two flipped bits. It holds the word in a rotating register and has a single voting unit, which always looks at bit 14. In each round, four parity checks that share only bit 14 are formed from the current word. If at least three of them fail, bit 14 is inverted. The word is then rotated by one place, so that bit 13 moves into the voting position. After fifteen rounds the word is back in its original alignment and every bit has been decided once.

A one-cycle `start` pulse loads the word. `done` pulses once when the result is ready. The corrected word and its seven information bits stay on the outputs until the next accepted start. A separate detector takes the full syndrome of the output word and reduces it with an OR. It raises `det_err` whenever the output is not a codeword.

A 15-bit word is a codeword when its polynomial, with bit i as the coefficient of x^i, is divisible by g(x)=1+x^4+x^6+x^7+x^8. Codewords are systematic: the message sits in bits 6..0 and the parity sits in bits 14..7.

Top module: `mlc_serial_corrector`

## Requirements
- R1: While reset is asserted and after it is released, `busy` and `done` are 0.
- R2: A `start` while idle loads `code_in` into the working word. In the next cycle `busy` is 1 and `word_out` equals the loaded word.
- R3: `done` is 1 for exactly one cycle. That cycle is the one after the fifteenth rotation edge, which is the 16th rising edge counted from the edge that accepted `start`. `busy` drops in the same cycle.
- R4: A word that is already a codeword is returned unchanged, with `det_err` at 0.
- R5: Any codeword with one flipped bit, in any of the 15 positions, is returned as the original codeword, with `det_err` at 0.
- R6: Any codeword with two flipped bits (all 105 position pairs) is returned as the original codeword, with `det_err` at 0.
- R7: `info_out` equals bits 6..0 of the corrected word. For correctable inputs, that is the original message.
- R8: `det_err` is 1 exactly when `word_out` is not divisible by g(x). This holds for any input, including patterns with three errors.
- R9: A `start` pulse while `busy` is 1 is ignored. The running result and the timing of `done` are unchanged.
- R10: While idle and without `start`, `word_out` and `info_out` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load request, honoured only while idle |
| code_in | input | 15 | Received word |
| busy | output | 1 | Correction rounds in progress |
| done | output | 1 | One-cycle result-ready pulse |
| word_out | output | 15 | Corrected word |
| info_out | output | 7 | Information bits 6..0 of the corrected word |
| det_err | output | 1 | Output word fails the syndrome check |

## Verification
A wrong vote or a wrong rotation leaves a bad bit in `word_out`. That bad bit is visible in the `done` cycle as a mismatch against the re-encoded message. It also sets `det_err`, because a corrected word cannot be off by one bit and still be a codeword. A round counter that is off by one either misaligns the whole word, which shows as a rotated result at `done`, or moves `done` by a cycle. Both effects appear on the first operation after reset. The sweeps use every message with zero or one error, plus every two-error pair on several messages, so a wrong check mask is exposed within a few operations.

// File: rtl/mlc_pkg.sv
package mlc_pkg;
  localparam int CW_N   = 15;              // code length
  localparam int CW_K   = 7;               // information bits
  localparam int CW_R   = CW_N - CW_K;     // syndrome bits
  localparam int N_CHK  = 4;               // orthogonal checks per bit
  localparam int VOTE_T = N_CHK / 2 + 1;   // flip threshold
  localparam int CNT_W  = $clog2(CW_N);

  typedef logic [CW_N-1:0] word_t;

  // Support of the dual-code generator polynomial 1+x+x^3+x^7
  localparam int TAP [N_CHK] = '{0, 1, 3, 7};

  // Parity-check row j: dual generator shifted by j positions
  function automatic word_t dual_row(input int j);
    word_t m;
    m = '0;
    for (int t = 0; t < N_CHK; t++) m[(TAP[t] + j) % CW_N] = 1'b1;
    return m;
  endfunction

  // Check i orthogonal on the top bit: shift that moves tap i onto bit N-1
  function automatic word_t ortho_mask(input int i);
    return dual_row(CW_N - 1 - TAP[i]);
  endfunction
endpackage

// File: rtl/mlc_vote.sv
module mlc_vote
  import mlc_pkg::*;
(
  input  word_t word_i,
  output logic  flip_o
);
  logic [N_CHK-1:0]       chk_fail;
  logic [$clog2(N_CHK+1)-1:0] fail_cnt;

  for (genvar i = 0; i < N_CHK; i++) begin : g_chk
    localparam word_t MASK = ortho_mask(i);
    assign chk_fail[i] = ^(word_i & MASK);
  end

  always_comb begin
    fail_cnt = '0;
    for (int i = 0; i < N_CHK; i++) fail_cnt = fail_cnt + {{($clog2(N_CHK+1)-1){1'b0}}, chk_fail[i]};
  end

  assign flip_o = (fail_cnt >= ($clog2(N_CHK+1))'(VOTE_T));
endmodule

// File: rtl/mlc_syndrome.sv
module mlc_syndrome
  import mlc_pkg::*;
(
  input  word_t word_i,
  output logic  err_o
);
  logic [CW_R-1:0] syn;

  for (genvar j = 0; j < CW_R; j++) begin : g_row
    localparam word_t ROW = dual_row(j);
    assign syn[j] = ^(word_i & ROW);
  end

  assign err_o = |syn;
endmodule

// File: rtl/mlc_sequencer.sv
module mlc_sequencer
  import mlc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load_o,
  output logic shift_o,
  output logic busy_o,
  output logic done_o
);
  typedef enum logic {S_IDLE, S_RUN} state_t;

  state_t           state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             last;

  assign last    = (cnt_q == CNT_W'(CW_N - 1));
  assign load_o  = (state_q == S_IDLE) && start;
  assign shift_o = (state_q == S_RUN);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    if (load_o) begin
      state_d = S_RUN;
      cnt_d   = '0;
    end else if (shift_o) begin
      cnt_d = cnt_q + 1'b1;
      if (last) begin
        state_d = S_IDLE;
        cnt_d   = '0;
        done_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  assign busy_o = (state_q == S_RUN);
  assign done_o = done_q;

  // independent round tally for checking
  logic [CNT_W:0] chk_rounds;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      chk_rounds <= '0;
    else if (load_o) chk_rounds <= '0;
    else if (busy_o) chk_rounds <= chk_rounds + 1'b1;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) $rose(rst_n) |-> (!busy_o && !done_o)); // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o); // R3
  AST_DONE_ROUNDS: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> (chk_rounds == (CNT_W+1)'(CW_N) && !busy_o)); // R3
  AST_BUSY_STEADY: assert property (@(posedge clk) disable iff (!rst_n) (busy_o && start && !last) |=> busy_o); // R9
endmodule

// File: rtl/mlc_serial_corrector.sv
module mlc_serial_corrector
  import mlc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [CW_N-1:0] code_in,
  output logic            busy,
  output logic            done,
  output logic [CW_N-1:0] word_out,
  output logic [CW_K-1:0] info_out,
  output logic            det_err
);
  word_t word_q, word_d, fixed;
  logic  load, shift, flip;

  mlc_sequencer u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .load_o (load),
    .shift_o(shift),
    .busy_o (busy),
    .done_o (done)
  );

  mlc_vote u_vote (
    .word_i(word_q),
    .flip_o(flip)
  );

  // decide the top bit, then rotate so bit N-2 takes its place
  always_comb begin
    fixed           = word_q;
    fixed[CW_N-1]   = word_q[CW_N-1] ^ flip;
    word_d          = word_q;
    if (load)       word_d = code_in;
    else if (shift) word_d = {fixed[CW_N-2:0], fixed[CW_N-1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              word_q <= '0;
    else if (load || shift)  word_q <= word_d;
  end

  mlc_syndrome u_syn (
    .word_i(word_q),
    .err_o (det_err)
  );

  assign word_out = word_q;
  assign info_out = word_q[CW_K-1:0];

  AST_LOAD_WORD: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> (busy && word_out == $past(code_in))); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !start) |=> ($stable(word_out) && $stable(info_out))); // R10
endmodule

// File: tb/mlc_serial_corrector_tb.sv
module mlc_serial_corrector_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [14:0] code_in = '0;
  logic        busy, done, det_err;
  logic [14:0] word_out;
  logic [6:0]  info_out;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  mlc_serial_corrector u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .code_in(code_in),
    .busy(busy), .done(done), .word_out(word_out), .info_out(info_out),
    .det_err(det_err)
  );

  function automatic logic [7:0] poly_rem(input logic [14:0] v_in);
    logic [14:0] v;
    v = v_in;
    for (int b = 14; b >= 8; b--)
      if (v[b]) v = v ^ (15'h1D1 << (b - 8));
    return v[7:0];
  endfunction

  function automatic logic [14:0] encode(input logic [6:0] m);
    logic [7:0] r;
    r = poly_rem({m, 8'h00});
    return {r, m};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [14:0] act, input logic [14:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // full operation; optional stray start at round 5
  task automatic run(input logic [14:0] rx, input logic [14:0] want, input bit want_ok,
                     input bit stray, input string tag, input bit timing);
    @(negedge clk); start = 1'b1; code_in = rx;
    @(negedge clk); start = 1'b0; code_in = ~rx;
    if (timing) check(busy && word_out == rx, "R2 load", word_out, rx);
    for (int c = 1; c < 15; c++) begin
      if (stray && c == 5) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (timing) check(!done && busy, "R3 early done", {13'd0, busy, done}, 15'd2);
    end
    @(negedge clk);
    check(done && !busy, "R3 done cycle", {13'd0, busy, done}, 15'd1);
    if (want_ok) begin
      check(word_out == want, tag, word_out, want);
      check(!det_err, "R8 flag clear", {14'd0, det_err}, 15'd0);
      check(info_out == want[6:0], "R7 info", {8'd0, info_out}, {8'd0, want[6:0]});
    end else begin
      check(det_err == (poly_rem(word_out) != 8'h00), "R8 flag vs divisibility",
            {14'd0, det_err}, {14'd0, poly_rem(word_out) != 8'h00});
    end
    @(negedge clk);
    if (timing) begin
      check(!done, "R3 single pulse", {14'd0, done}, 15'd0);
      repeat (3) @(negedge clk);
      check(word_out == want || !want_ok, "R10 hold", word_out, want);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [14:0] cw;
    logic [6:0]  msg;
    #1;
    check(!busy && !done, "R1 in reset", {13'd0, busy, done}, 15'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done, "R1 after reset", {13'd0, busy, done}, 15'd0);

    // R4 / R5: every message, clean and with each single error
    for (int m = 0; m < 128; m++) begin
      cw = encode(7'(m));
      run(cw, cw, 1'b1, 1'b0, "R4 clean word", m < 2);
      for (int p = 0; p < 15; p++)
        run(cw ^ (15'd1 << p), cw, 1'b1, 1'b0, "R5 single error", 1'b0);
    end

    // R6: all pairs on several messages
    msg = 7'h35;
    for (int k = 0; k < 8; k++) begin
      msg = msg * 7'd29 + 7'd17;
      cw = encode(msg);
      for (int a = 0; a < 15; a++)
        for (int b = a + 1; b < 15; b++)
          run(cw ^ (15'd1 << a) ^ (15'd1 << b), cw, 1'b1, 1'b0, "R6 double error", 1'b0);
    end

    // R9: stray start mid-run, with timing checks
    cw = encode(7'h5A);
    run(cw ^ 15'h0201, cw, 1'b1, 1'b1, "R9 stray start", 1'b1);

    // R8: triple errors, flag must track divisibility of the output
    cw = encode(7'h13);
    for (int a = 0; a < 13; a++)
      run(cw ^ (15'd7 << a), cw, 1'b0, 1'b0, "R8 triple", 1'b0);
    for (int a = 0; a < 11; a++)
      run(cw ^ (15'h15 << a), cw, 1'b0, 1'b0, "R8 triple", 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule